// File: doc/BRIEF.md
# Power-Off Grace Watchdog

This block gives software a bounded amount of time to finish its work after the user turns the unit off. A raw on/off switch level enters the block. The block resynchronises it, filters it, and while it reads "on" the block keeps the grace counter at zero and holds the regulator-enable output high. Once the filtered level reads "off", the counter advances on every 32.768 kHz tick. If it reaches the programmed terminal count, the block drops the regulator enable, and that output stays low until the next reset.

The host reaches the block over a write-only SPI slave. One register address restarts the grace period. A second address carries a reference-clock enable bit, which comes out of reset cleared. A third address sets the upper part of the timeout. At the default value the window is 65536 ticks, which is 2 s. All logic runs on the system clock, and the SPI pins are sampled as ordinary inputs.

Top module: `pwroff_grace_wdt`

## Requirements
- R1: After reset `reg_en` is 1 and `refclk_en` is 0.
- R2: `sw_sense_raw` is active low: 1 means off and 0 means on. The block passes it through a two-flop synchroniser. It acts on a new level only after that level has been seen on DEB_TICKS (4) consecutive ticks. A shorter excursion has no effect.
- R3: While the filtered switch reads on, ticks never advance the counter, and `reg_en` stays 1 however many ticks arrive.
- R4: While the filtered switch reads off, each tick advances the counter. `reg_en` falls on the clock edge of tick number (T+1)*2^(CNT_W-HI_W) counted from the first tick after the off level is accepted. T is the timeout field.
- R5: An SPI frame is mode 0. Bits are taken on rising `spi_sclk` while `spi_cs_n` is low, MSB first. A frame is 16 bits: an 8-bit address followed by 8-bit data. It takes effect when its 16th bit arrives.
- R6: A frame to address 0x01, with any data, restarts the grace count from zero. A full window is needed after it.
- R7: A frame to address 0x02 copies data bit 0 into `refclk_en`. Data bits 7..1 are ignored.
- R8: A frame to address 0x03 loads data bits HI_W-1..0 into the timeout field T. Reset sets T to all ones.
- R9: If the switch returns to on before expiry, the count clears. The next off period gets a full window.
- R10: Once `reg_en` is 0 it stays 0 until reset, even if the switch returns to on or a refresh is written.
- R11: Frames to any other address, and frames cut short by `spi_cs_n` rising before 16 bits, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle pulse at 32.768 kHz |
| sw_sense_raw | input | 1 | Raw switch level, 1 = off, 0 = on |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data in, MSB first |
| reg_en | output | 1 | Regulator enable, low shuts the supply down |
| refclk_en | output | 1 | Reference-clock enable from register 0x02 bit 0 |

## Verification
The bench builds the block with CNT_W=10, HI_W=8 and DEB_TICKS=4. This makes the window (T+1)*4 ticks, so the default T of 0xFF expires after 1024 ticks instead of 65536. With a short window, the bench can step through exact expiry edges for the default and for random small T values, with and without a refresh. It also covers the on-before-expiry restart and the latched shutdown, all within a short run.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int FRAME_W = 16;

    localparam logic [7:0] ADDR_REFRESH = 8'h01;
    localparam logic [7:0] ADDR_CTRL    = 8'h02;
    localparam logic [7:0] ADDR_TMO_HI  = 8'h03;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } spi_frame_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_REFRESH,
        OP_CTRL,
        OP_TMO
    } reg_op_e;

    function automatic reg_op_e decode_op(input spi_frame_t f);
        case (f.addr)
            ADDR_REFRESH: return OP_REFRESH;
            ADDR_CTRL:    return OP_CTRL;
            ADDR_TMO_HI:  return OP_TMO;
            default:      return OP_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pgw_sw_filter.sv
module pgw_sw_filter #(
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sw_raw,
    output logic sw_off
);
    localparam int DW = $clog2(DEB_TICKS + 1);

    logic [1:0]    sync_q;
    logic [DW-1:0] deb_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b00;
            deb_cnt <= '0;
            sw_off  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], sw_raw};
            if (sync_q[1] == sw_off) begin
                deb_cnt <= '0;
            end else if (tick) begin
                if (deb_cnt == DW'(DEB_TICKS - 1)) begin
                    sw_off  <= sync_q[1];
                    deb_cnt <= '0;
                end else begin
                    deb_cnt <= deb_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pgw_spi_rx.sv
module pgw_spi_rx
    import pgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       frm_vld,
    output spi_frame_t frm
);
    localparam int BW = $clog2(FRAME_W + 1);

    logic [1:0]         sclk_s, cs_s, mosi_s;
    logic               sclk_d;
    logic               rise;
    logic [BW-1:0]      bit_cnt;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s <= 2'b00;
            cs_s   <= 2'b11;
            mosi_s <= 2'b00;
            sclk_d <= 1'b0;
        end else begin
            sclk_s <= {sclk_s[0], sclk};
            cs_s   <= {cs_s[0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
            sclk_d <= sclk_s[1];
        end
    end

    assign rise = sclk_s[1] & ~sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
            frm_vld <= 1'b0;
        end else begin
            frm_vld <= 1'b0;
            if (cs_s[1]) begin
                bit_cnt <= '0;
            end else if (rise && bit_cnt < BW'(FRAME_W)) begin
                shreg   <= {shreg[FRAME_W-2:0], mosi_s[1]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BW'(FRAME_W - 1)) frm_vld <= 1'b1;
            end
        end
    end

    assign frm = spi_frame_t'(shreg);
endmodule

// File: rtl/pgw_regs.sv
module pgw_regs
    import pgw_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frm_vld,
    input  spi_frame_t      frm,
    output logic            refresh,
    output logic            refclk_en,
    output logic [HI_W-1:0] tmo_hi
);
    reg_op_e op;
    logic    unused_data;

    assign op          = frm_vld ? decode_op(frm) : OP_NONE;
    assign refresh     = (op == OP_REFRESH);
    assign unused_data = ^frm.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            refclk_en <= 1'b0;
            tmo_hi    <= '1;
        end else begin
            case (op)
                OP_CTRL: refclk_en <= frm.data[0];
                OP_TMO:  tmo_hi    <= frm.data[HI_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pgw_grace_counter.sv
module pgw_grace_counter #(
    parameter int CNT_W = 16,
    parameter int HI_W  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            sw_off,
    input  logic            refresh,
    input  logic [HI_W-1:0] tmo_hi,
    output logic            expired
);
    localparam int LOW_W = CNT_W - HI_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;

    assign term = {tmo_hi, {LOW_W{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else if (!sw_off) begin
            cnt_q <= '0;
        end else if (!expired) begin
            if (refresh) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == term) expired <= 1'b1;
                else               cnt_q   <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwroff_grace_wdt.sv
module pwroff_grace_wdt
    import pgw_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int HI_W      = 8,
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_32k,
    input  logic sw_sense_raw,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic reg_en,
    output logic refclk_en
);
    logic            sw_off_db;
    logic            frm_vld;
    spi_frame_t      frm;
    logic            refresh;
    logic [HI_W-1:0] tmo_hi;
    logic            expired;

    pgw_sw_filter #(.DEB_TICKS(DEB_TICKS)) u_filt (
        .clk(clk), .rst(rst), .tick(tick_32k),
        .sw_raw(sw_sense_raw), .sw_off(sw_off_db)
    );

    pgw_spi_rx u_spi (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .frm_vld(frm_vld), .frm(frm)
    );

    pgw_regs #(.HI_W(HI_W)) u_regs (
        .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm(frm),
        .refresh(refresh), .refclk_en(refclk_en), .tmo_hi(tmo_hi)
    );

    pgw_grace_counter #(.CNT_W(CNT_W), .HI_W(HI_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_32k), .sw_off(sw_off_db),
        .refresh(refresh), .tmo_hi(tmo_hi), .expired(expired)
    );

    assign reg_en = ~expired;
endmodule

// File: rtl/pwroff_grace_wdt_chk.sv
module pwroff_grace_wdt_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic sw_off,
    input logic frm_vld,
    input logic reg_en,
    input logic refclk_en
);
    // R1: outputs come out of reset in their defined state
    p_reset_state_r1: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (reg_en && !refclk_en));

    // R3: shutdown only happens while the filtered switch reads off
    p_no_fall_when_on_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_en) |-> $past(sw_off));

    // R4: shutdown is driven by a counting tick
    p_fall_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_en) |-> $past(tick));

    // R10: shutdown is latched
    p_latched_low_r10: assert property (@(posedge clk) disable iff (rst)
        !reg_en |=> !reg_en);

    // R7: clock enable moves only after a completed frame
    p_refclk_on_frame_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(refclk_en) |-> $past(frm_vld));
endmodule

bind pwroff_grace_wdt pwroff_grace_wdt_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick_32k), .sw_off(sw_off_db),
    .frm_vld(frm_vld), .reg_en(reg_en), .refclk_en(refclk_en)
);

// File: tb/pwroff_grace_wdt_bench.sv
`timescale 1ns/1ps
module pwroff_grace_wdt_bench;
    localparam int CNT_W = 10;
    localparam int HI_W  = 8;
    localparam int DEB   = 4;
    localparam int LOW_W = CNT_W - HI_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_32k = 1'b0;
    logic sw_sense_raw = 1'b0;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic reg_en, refclk_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwroff_grace_wdt #(.CNT_W(CNT_W), .HI_W(HI_W), .DEB_TICKS(DEB)) u_pwroff_grace_wdt (
        .clk(clk), .rst(rst), .tick_32k(tick_32k), .sw_sense_raw(sw_sense_raw),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .reg_en(reg_en), .refclk_en(refclk_en)
    );

    function automatic int window(input int t);
        return (t + 1) << LOW_W;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sw_sense_raw = 1'b0; tick_32k = 1'b0;
        spi_cs_n = 1'b1; spi_sclk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_32k = 1'b1;
            @(negedge clk); tick_32k = 1'b0;
        end
    endtask

    task automatic spi_send(input logic [7:0] a, input logic [7:0] d, input int nbits);
        logic [15:0] w;
        w = {a, d};
        @(negedge clk); spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = w[15 - i];
            repeat (4) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic set_sw(input logic off);
        sw_sense_raw = off;
        repeat (3) @(negedge clk);
        ticks(DEB);
    endtask

    task automatic expect_expiry(input int n, input string req);
        ticks(n - 1);
        chk(reg_en == 1'b1, req, reg_en, 1);
        ticks(1);
        chk(reg_en == 1'b0, req, reg_en, 0);
    endtask

    initial begin
        int w, k, t, rem;
        bit doref;
        void'($urandom(32'd4242));
        do_reset();

        // R1 reset state
        chk(reg_en == 1'b1, "R1", reg_en, 1);
        chk(refclk_en == 1'b0, "R1", refclk_en, 0);

        // R3 switch on, many ticks
        ticks(window(255) + 50);
        chk(reg_en == 1'b1, "R3", reg_en, 1);

        // R2 short off glitch ignored
        sw_sense_raw = 1'b1;
        repeat (3) @(negedge clk);
        ticks(DEB - 1);
        sw_sense_raw = 1'b0;
        repeat (3) @(negedge clk);
        ticks(window(255) + 20);
        chk(reg_en == 1'b1, "R2", reg_en, 1);

        // R4 R8 default timeout, exact edge
        set_sw(1'b1);
        expect_expiry(window(255), "R4/R8 default");

        // R10 latched low
        set_sw(1'b0);
        spi_send(8'h01, 8'h00, 16);
        ticks(10);
        chk(reg_en == 1'b0, "R10", reg_en, 0);
        do_reset();
        chk(reg_en == 1'b1, "R10 reset", reg_en, 1);

        // R5 R7 control bit, other bits ignored
        spi_send(8'h02, 8'hFE, 16);
        chk(refclk_en == 1'b0, "R7 bit0 only", refclk_en, 0);
        // R11 truncated frame has no effect
        spi_send(8'h02, 8'h01, 12);
        chk(refclk_en == 1'b0, "R11 short frame", refclk_en, 0);
        spi_send(8'h02, 8'h01, 16);
        chk(refclk_en == 1'b1, "R5 R7 set", refclk_en, 1);
        spi_send(8'h05, 8'h00, 16);
        chk(refclk_en == 1'b1, "R11 bad addr", refclk_en, 1);
        spi_send(8'h02, 8'h00, 16);
        chk(refclk_en == 1'b0, "R7 clear", refclk_en, 0);

        // R8 program T=2, R11 unused address leaves T alone
        spi_send(8'h03, 8'h02, 16);
        spi_send(8'h04, 8'h00, 16);
        // R9 return to on before expiry
        w = window(2);
        set_sw(1'b1);
        ticks(w - 8);
        set_sw(1'b0);
        chk(reg_en == 1'b1, "R9", reg_en, 1);
        set_sw(1'b1);
        expect_expiry(w, "R9 R8 R11 full window");

        // R6 refresh directed
        do_reset();
        spi_send(8'h03, 8'h01, 16);
        set_sw(1'b1);
        ticks(window(1) - 1);
        spi_send(8'h01, 8'h5A, 16);
        expect_expiry(window(1), "R6 refresh");

        // Random: R4 R6 R8
        for (int it = 0; it < 8; it++) begin
            do_reset();
            t = $urandom_range(0, 7);
            w = window(t);
            spi_send(8'h03, 8'(t), 16);
            set_sw(1'b1);
            k = $urandom_range(0, w - 1);
            ticks(k);
            doref = 1'($urandom_range(0, 1));
            if (doref) begin
                spi_send(8'h01, 8'(it), 16);
                rem = w;
            end else begin
                rem = w - k;
            end
            expect_expiry(rem, doref ? "R6 random" : "R4 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule